// File: doc/BRIEF.md
# Four-Channel Saturating Audio Mixer

This block combines four signed 16-bit sample streams into one 16-bit output stream. All streams run at one common sample rate, and a single strobe marks each sample period. Each channel has its own volume code. The code selects an attenuation from a 128-entry logarithmic gain table. That attenuation scales the channel's sample before the four results are added together.

The sum is clamped to the 16-bit range, so it never wraps. A master attenuator then scales the clamped value. The master has its own code register, which is loaded through a load pulse.

Each channel's code normally follows its input code on the next clock. When fading is enabled, the codes move toward their targets one step at a time instead. A step happens once every programmable number of strobes. A channel contributes to the sum only when its sample is both valid and active. Deasserting either input silences that channel from the very next output sample.

Top module: `audio_mix4`

## Requirements
- R1: After reset, `mix_out` is 0 and `mix_stb` is 0. Every channel volume code is 0 and the master code is `MST_RST`, which defaults to 59 (about -4 dB).
- R2: A strobe sampled on clock edge k gives `mix_stb` = 1 for exactly one cycle, after edge k+2, with the new `mix_out`. Between output pulses, `mix_out` holds its value.
- R3: The gain for code c starts at 65536 and applies g := g - floor(g/128) c times. Code 0 is exact unity, and larger codes attenuate more.
- R4: Every attenuator computes (x * g) / 65536 rounded toward zero. For example, -1 at code 1 gives 0.
- R5: A channel adds its scaled sample only when its `ch_valid` and `ch_active` bits are both 1 in the strobe cycle. Otherwise it adds 0 for that sample. Channel i uses bits [16i+15:16i] of `ch_data` and [7i+6:7i] of `ch_vol`.
- R6: The four scaled samples are summed at full width. The sum is then clamped to [-32768, 32767] rather than wrapped.
- R7: The master attenuation uses the master code on the clamped sum. A `mst_load` pulse copies `mst_code` into the master code. The master code changes for no other reason.
- R8: With `fade_on` = 0, each channel code equals that channel's `ch_vol` field one clock later. Each channel's code is independent of the other channels.
- R9: With `fade_on` = 1, a strobe counter runs from 0 to `fade_div`. On the strobe where the counter equals `fade_div`, the counter wraps and every code that differs from its target moves one step toward it. The counter is held at 0 while fading is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle sample-period strobe |
| ch_data | input | 64 | Four signed 16-bit samples, channel 0 in the low bits |
| ch_valid | input | 4 | Per-channel sample-valid flags |
| ch_active | input | 4 | Per-channel playing flags |
| ch_vol | input | 28 | Four 7-bit volume target codes |
| fade_on | input | 1 | Enables stepwise volume ramps |
| fade_div | input | 8 | Strobes per fade step, minus one |
| mst_load | input | 1 | Loads the master code |
| mst_code | input | 7 | New master attenuation code |
| mix_out | output | 16 | Mixed, clamped and master-scaled sample |
| mix_stb | output | 1 | Marks a new `mix_out` |

## Verification
A corrupted channel code or fade counter appears at `mix_out` on the next output sample. It shows up as a level that does not match the expected gain, because the bench tracks the expected code of every channel strobe by strobe. A wrong clamp or wrong rounding appears in the very sample that drives the sum past full scale, or that scales a small negative value. A master code that changes without a load pulse alters every later output until it is reloaded.

// File: rtl/mix_pkg.sv
package mix_pkg;
  localparam int GAIN_FRAC = 16;
  localparam int GAIN_W    = GAIN_FRAC + 1;

  // Logarithmic gain: each code step multiplies by (1 - 1/128).
  function automatic logic [GAIN_W-1:0] gain_of(input int code);
    int g;
    g = 1 << GAIN_FRAC;
    for (int i = 0; i < code; i++) g = g - (g >>> 7);
    return GAIN_W'(g);
  endfunction
endpackage

// File: rtl/mix_gain_rom.sv
module mix_gain_rom #(
  parameter int CW = 7
) (
  input  logic [CW-1:0]              code,
  output logic [mix_pkg::GAIN_W-1:0] gain
);
  localparam int DEPTH = 1 << CW;
  logic [mix_pkg::GAIN_W-1:0] tab [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign tab[i] = mix_pkg::gain_of(i);
  end

  assign gain = tab[code];
endmodule

// File: rtl/mix_scale.sv
module mix_scale #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0]        x,
  input  logic [mix_pkg::GAIN_W-1:0]  g,
  output logic signed [DW-1:0]        y
);
  localparam int PW = DW + mix_pkg::GAIN_W + 1;
  logic signed [PW-1:0] p, q;

  always_comb begin
    p = PW'(x) * PW'($signed({1'b0, g}));
    q = p >>> mix_pkg::GAIN_FRAC;
    // floor -> toward zero for negative products with a remainder
    if (p[PW-1] && (|p[mix_pkg::GAIN_FRAC-1:0])) q = q + PW'(1);
    y = q[DW-1:0];
  end
endmodule

// File: rtl/mix_chan.sv
module mix_chan #(
  parameter int DW = 16,
  parameter int CW = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stb,
  input  logic                 step,
  input  logic                 fade_on,
  input  logic [CW-1:0]        tgt,
  input  logic signed [DW-1:0] smp,
  input  logic                 vld,
  input  logic                 act,
  output logic [CW-1:0]        cur,
  output logic signed [DW-1:0] contrib
);
  logic [mix_pkg::GAIN_W-1:0] gain;
  logic signed [DW-1:0]       scaled;

  mix_gain_rom #(.CW(CW)) u_rom (.code(cur), .gain(gain));
  mix_scale    #(.DW(DW)) u_scl (.x(smp), .g(gain), .y(scaled));

  always_ff @(posedge clk) begin
    if (rst) begin
      cur     <= '0;
      contrib <= '0;
    end else begin
      if (!fade_on)
        cur <= tgt;
      else if (stb && step && (cur != tgt))
        cur <= (cur < tgt) ? cur + CW'(1) : cur - CW'(1);
      if (stb)
        contrib <= (vld && act) ? scaled : '0;
    end
  end
endmodule

// File: rtl/audio_mix4.sv
module audio_mix4 #(
  parameter int NCH     = 4,
  parameter int DW      = 16,
  parameter int CW      = 7,
  parameter int PW      = 8,
  parameter int MST_RST = 59
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_stb,
  input  logic [NCH*DW-1:0] ch_data,
  input  logic [NCH-1:0]    ch_valid,
  input  logic [NCH-1:0]    ch_active,
  input  logic [NCH*CW-1:0] ch_vol,
  input  logic              fade_on,
  input  logic [PW-1:0]     fade_div,
  input  logic              mst_load,
  input  logic [CW-1:0]     mst_code,
  output logic [DW-1:0]     mix_out,
  output logic              mix_stb
);
  localparam int SW = DW + $clog2(NCH) + 1;
  localparam logic signed [SW-1:0] MAXV = SW'((1 << (DW-1)) - 1);
  localparam logic signed [SW-1:0] MINV = -SW'(1 << (DW-1));

  logic [PW-1:0]     fcnt;
  logic              fstep;
  logic [NCH*DW-1:0] contrib_bus;
  logic [NCH*CW-1:0] cur_bus;
  logic              v1, v2;
  logic signed [SW-1:0] acc;
  logic signed [DW-1:0] sat_r, mst_y;
  logic [CW-1:0]        mst_r;
  logic [mix_pkg::GAIN_W-1:0] mgain;

  assign fstep = (fcnt == fade_div);

  always_ff @(posedge clk) begin
    if (rst || !fade_on) fcnt <= '0;
    else if (smp_stb)    fcnt <= fstep ? '0 : fcnt + PW'(1);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    mix_chan #(.DW(DW), .CW(CW)) u_ch (
      .clk(clk), .rst(rst), .stb(smp_stb), .step(fstep), .fade_on(fade_on),
      .tgt(ch_vol[i*CW +: CW]), .smp(ch_data[i*DW +: DW]),
      .vld(ch_valid[i]), .act(ch_active[i]),
      .cur(cur_bus[i*CW +: CW]), .contrib(contrib_bus[i*DW +: DW])
    );
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < NCH; i++)
      acc = acc + SW'($signed(contrib_bus[i*DW +: DW]));
  end

  mix_gain_rom #(.CW(CW)) u_mrom (.code(mst_r), .gain(mgain));
  mix_scale    #(.DW(DW)) u_mscl (.x(sat_r), .g(mgain), .y(mst_y));

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; v2 <= 1'b0; mix_stb <= 1'b0;
      sat_r <= '0; mix_out <= '0;
      mst_r <= CW'(MST_RST);
    end else begin
      v1 <= smp_stb;
      v2 <= v1;
      mix_stb <= v2;
      if (mst_load) mst_r <= mst_code;
      if (v1) begin
        if (acc > MAXV)      sat_r <= MAXV[DW-1:0];
        else if (acc < MINV) sat_r <= MINV[DW-1:0];
        else                 sat_r <= acc[DW-1:0];
      end
      if (v2) mix_out <= mst_y;
    end
  end
endmodule

// File: rtl/audio_mix4_chk.sv
module audio_mix4_chk #(
  parameter int NCH = 4,
  parameter int DW  = 16,
  parameter int CW  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              smp_stb,
  input logic              fade_on,
  input logic              mst_load,
  input logic              mix_stb,
  input logic [DW-1:0]     mix_out,
  input logic [NCH*CW-1:0] cur_bus,
  input logic [NCH*CW-1:0] ch_vol,
  input logic [CW-1:0]     mst_r
);
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_out_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (mix_stb == $past(smp_stb, 3)));

  assert_out_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && !mix_stb) |-> $stable(mix_out));

  assert_master_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && !$past(mst_load)) |-> $stable(mst_r));

  for (genvar i = 0; i < NCH; i++) begin : g_c
    assert_follow_R8: assert property (@(posedge clk) disable iff (rst)
      (since_rst != 2'd0 && !$past(fade_on)) |->
        (cur_bus[i*CW +: CW] == $past(ch_vol[i*CW +: CW])));

    assert_fade_only_on_strobe_R9: assert property (@(posedge clk) disable iff (rst)
      (since_rst != 2'd0 && $past(fade_on) && !$past(smp_stb)) |->
        $stable(cur_bus[i*CW +: CW]));

    assert_fade_single_step_R9: assert property (@(posedge clk) disable iff (rst)
      (since_rst != 2'd0 && $past(fade_on)) |->
        ((cur_bus[i*CW +: CW] == $past(cur_bus[i*CW +: CW])) ||
         (cur_bus[i*CW +: CW] == $past(cur_bus[i*CW +: CW]) + CW'(1)) ||
         (cur_bus[i*CW +: CW] == $past(cur_bus[i*CW +: CW]) - CW'(1))));
  end
endmodule

bind audio_mix4 audio_mix4_chk #(.NCH(NCH), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .smp_stb(smp_stb), .fade_on(fade_on),
  .mst_load(mst_load), .mix_stb(mix_stb), .mix_out(mix_out),
  .cur_bus(cur_bus), .ch_vol(ch_vol), .mst_r(mst_r)
);

// File: tb/audio_mix4_bench.sv
`timescale 1ns/1ps
module audio_mix4_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_stb = 1'b0;
  logic [63:0] ch_data = '0;
  logic [3:0]  ch_valid = '0, ch_active = '0;
  logic [27:0] ch_vol = '0;
  logic        fade_on = 1'b0;
  logic [7:0]  fade_div = '0;
  logic        mst_load = 1'b0;
  logic [6:0]  mst_code = '0;
  logic [15:0] mix_out;
  logic        mix_stb;

  int total = 0, bad = 0;
  bit finished = 0;

  int s_data[4];
  bit s_val[4], s_act[4];
  int m_cur[4], m_tgt[4];
  int m_mst = 59, m_fcnt = 0, m_div = 0;
  bit m_fade = 0;
  int exp_out;

  always #2.5 clk = ~clk;

  audio_mix4 u_audio_mix4 (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .ch_data(ch_data),
    .ch_valid(ch_valid), .ch_active(ch_active), .ch_vol(ch_vol),
    .fade_on(fade_on), .fade_div(fade_div), .mst_load(mst_load),
    .mst_code(mst_code), .mix_out(mix_out), .mix_stb(mix_stb)
  );

  function automatic int bgain(int c);
    int g = 65536;
    for (int i = 0; i < c; i++) g = g - g / 128;
    return g;
  endfunction

  function automatic int bscale(int x, int g);
    longint p = longint'(x) * longint'(g);
    return int'(p / 65536);
  endfunction

  function automatic int bsat(int s);
    if (s > 32767) return 32767;
    if (s < -32768) return -32768;
    return s;
  endfunction

  task automatic chk(string req, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic set_vols(int c0, int c1, int c2, int c3);
    @(negedge clk);
    m_tgt[0] = c0; m_tgt[1] = c1; m_tgt[2] = c2; m_tgt[3] = c3;
    for (int i = 0; i < 4; i++) begin
      ch_vol[i*7 +: 7] = 7'(m_tgt[i]);
      if (!m_fade) m_cur[i] = m_tgt[i];
    end
  endtask

  task automatic set_fade(bit on, int dv);
    @(negedge clk);
    fade_on = on; fade_div = 8'(dv);
    m_fade = on; m_div = dv; m_fcnt = 0;
    if (!on) for (int i = 0; i < 4; i++) m_cur[i] = m_tgt[i];
  endtask

  task automatic set_master(int c);
    @(negedge clk);
    mst_code = 7'(c); mst_load = 1'b1;
    @(negedge clk);
    mst_load = 1'b0;
    m_mst = c;
  endtask

  // drive one strobe, predict, and check the output 3 edges later
  task automatic do_strobe(string req);
    int sum = 0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      ch_data[i*16 +: 16] = 16'(s_data[i]);
      ch_valid[i] = s_val[i];
      ch_active[i] = s_act[i];
      if (s_val[i] && s_act[i]) sum += bscale(s_data[i], bgain(m_cur[i]));
    end
    exp_out = bscale(bsat(sum), bgain(m_mst));
    if (m_fade) begin
      if (m_fcnt == m_div) begin
        m_fcnt = 0;
        for (int i = 0; i < 4; i++)
          if (m_cur[i] < m_tgt[i]) m_cur[i]++;
          else if (m_cur[i] > m_tgt[i]) m_cur[i]--;
      end else m_fcnt++;
    end
    smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk("R2 strobe", int'(mix_stb), 1);
    chk(req, int'($signed(mix_out)), exp_out);
  endtask

  task automatic one_ch(int x);
    s_data[0] = x; s_val[0] = 1; s_act[0] = 1;
    for (int i = 1; i < 4; i++) begin s_data[i] = 0; s_val[i] = 0; s_act[i] = 0; end
  endtask

  initial begin
    #500us;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 4; i++) begin m_cur[i] = 0; m_tgt[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    chk("R1 out", int'(mix_out), 0);
    chk("R1 stb", int'(mix_stb), 0);

    // R1/R7: master reset code 59 applied to a unity channel
    one_ch(10000);
    do_strobe("R1 master reset");
    @(posedge clk); #1;
    chk("R2 single pulse", int'(mix_stb), 0);
    chk("R2 hold", int'($signed(mix_out)), exp_out);

    set_master(0);
    one_ch(12345);
    do_strobe("R3 unity code0");
    set_vols(1, 0, 0, 0);
    one_ch(-1);
    do_strobe("R4 toward zero");
    set_vols(37, 0, 0, 0);
    one_ch(-30001);
    do_strobe("R3 R4 code37");

    // R5 gating: inactive and invalid channels contribute nothing
    set_vols(0, 0, 0, 0);
    s_data = '{1000, 2000, 3000, 4000};
    s_val = '{1, 1, 0, 1}; s_act = '{1, 0, 1, 1};
    do_strobe("R5 gating");
    exp_out = 5000;
    chk("R5 gated sum", int'($signed(mix_out)), exp_out);
    one_ch(20000); do_strobe("R5 playing");
    s_act[0] = 0;  do_strobe("R5 stopped");
    chk("R5 stopped zero", int'($signed(mix_out)), 0);

    // R6 saturation both ways
    s_data = '{32767, 32767, 32767, 32767};
    s_val = '{1, 1, 1, 1}; s_act = '{1, 1, 1, 1};
    do_strobe("R6 clamp high");
    chk("R6 max", int'($signed(mix_out)), 32767);
    s_data = '{-32768, -32768, -20000, 0};
    do_strobe("R6 clamp low");
    chk("R6 min", int'($signed(mix_out)), -32768);
    set_master(20);
    do_strobe("R7 master after clamp");

    // R8 independent channel codes, no fade
    set_master(0);
    set_vols(0, 40, 127, 5);
    s_data = '{3000, -7000, 32767, 100};
    do_strobe("R8 independent codes");

    // R9 fade ramp down then up, step every 2 strobes
    set_vols(0, 0, 0, 0);
    set_fade(1, 1);
    set_vols(6, 0, 0, 0);
    one_ch(20000);
    for (int k = 0; k < 14; k++) do_strobe("R9 ramp");
    chk("R9 reached", int'($signed(mix_out)), bscale(20000, bgain(6)));
    set_vols(3, 0, 0, 0);
    set_fade(1, 0);
    for (int k = 0; k < 4; k++) do_strobe("R9 ramp every strobe");
    set_vols(100, 0, 0, 0);
    do_strobe("R9 one step");
    set_fade(0, 0);
    do_strobe("R8 jump after fade off");

    // random mix
    for (int n = 0; n < 40; n++) begin
      set_vols($urandom_range(0, 127), $urandom_range(0, 127),
               $urandom_range(0, 20), $urandom_range(0, 127));
      if (n % 10 == 3) set_master($urandom_range(0, 127));
      for (int i = 0; i < 4; i++) begin
        s_data[i] = int'($urandom_range(0, 65535)) - 32768;
        s_val[i] = ($urandom_range(0, 7) != 0);
        s_act[i] = ($urandom_range(0, 7) != 0);
      end
      do_strobe("R6 R8 random");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule